// File: doc/BRIEF.md
# Aligned Power-of-Two Entry Allocator

This block keeps the occupancy map of an interrupt entry table and hands out slots in naturally aligned groups whose size is a power of two. A client asks for a number of entries; the block rounds that number up to a power of two and returns the lowest base index whose whole aligned group is free, together with the size exponent. The same request port also releases a group, preloads the map from an earlier table, and asks whether the whole unit can be removed. The entry contents live elsewhere. The block only tracks which slots are taken.

Every release that really frees entries raises a one-cycle invalidate pulse. The pulse carries the base index and the exponent, so a downstream entry cache can drop exactly that range. Requests enter through a valid/ready handshake. Each accepted request produces exactly one response pulse. The free-group search tests one aligned candidate per cycle, so the port is busy while a search runs.

Top module: `pow2_region_alloc`

## Requirements
- R1: An allocate request (reqOp = 2'b00) with reqCount = 0 answers in the cycle after acceptance with rspOk = 0, rspIndex = 0 and rspMask = 0, and the map is left unchanged.
- R2: The size exponent of an allocation is the smallest m with 2^m >= reqCount. A count of 1 gives m = 0. A successful allocation reports m on rspMask.
- R3: An allocate request whose exponent exceeds MaxHandleMask fails in the cycle after acceptance with rspOk = 0, and no entry is marked.
- R4: A successful allocation marks all 2^m entries of the returned group as used and reports rspOk = 1. The group is the lowest aligned free one. The response appears 2 + j cycles after acceptance, where j is the candidate's position base/2^m.
- R5: Every base index returned by a successful allocation is a multiple of 2^m.
- R6: When no aligned group of size 2^m is free, the response has rspOk = 0 and appears 1 + Entries/2^m cycles after acceptance. The map is left unchanged.
- R7: A release (reqOp = 2'b01) with reqSubHandle = 0 clears the 2^reqMask entries starting at reqIndex (entries past the table end are ignored). In the cycle after acceptance it answers rspOk = 1 and pulses invValid with invIndex = reqIndex and invMask = reqMask.
- R8: A release with a nonzero reqSubHandle clears nothing and raises no invalidate. It still answers rspOk = 1 in the cycle after acceptance.
- R9: A preload (reqOp = 2'b10) with reqPresent = 1 marks entry reqIndex as used. With reqPresent = 0 it changes nothing. Either way it answers rspOk = 1 in the cycle after acceptance.
- R10: A removal query (reqOp = 2'b11) answers rspOk = 0 (busy) while any entry is used, and rspOk = 1 when the map is empty, in the cycle after acceptance.
- R11: Out of reset the map is empty, reqReady = 1, and neither rspValid nor invValid is raised.
- R12: reqReady is low while a free-group search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqOp | input | 2 | 00 allocate, 01 release, 10 preload, 11 removal query |
| reqCount | input | CountW | Number of entries wanted (allocate) |
| reqIndex | input | log2(Entries) | Base index (release) or entry index (preload) |
| reqMask | input | MaskW | Size exponent of the group to release |
| reqSubHandle | input | SubHandleW | Sub-handle of the release; nonzero makes it a no-op |
| reqPresent | input | 1 | Present bit of the preloaded entry |
| rspValid | output | 1 | One-cycle response pulse |
| rspOk | output | 1 | Success / granted |
| rspIndex | output | log2(Entries) | Allocated base index (0 unless an allocation succeeds) |
| rspMask | output | MaskW | Allocated size exponent (0 unless an allocation succeeds) |
| invValid | output | 1 | One-cycle invalidate request |
| invIndex | output | log2(Entries) | Base index of the invalidated range |
| invMask | output | MaskW | Size exponent of the invalidated range |

## Verification
Release, preload, removal and rejected allocations answer in the first cycle after the accepting edge. A search answers 2 + j cycles after acceptance when it finds the group at candidate j, and 1 + Entries/2^m cycles after acceptance when it finds nothing. At acceptance, the driver's reference map gives the expected due cycle of every response and invalidate. The monitor compares each pulse against that cycle and flags any item whose due cycle passes without a pulse. Sampling is done on the falling edge, so every registered output has already settled for the cycle being checked.

// File: rtl/pow2_region_pkg.sv
package pow2_region_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC   = 2'b00,
    OP_RELEASE = 2'b01,
    OP_PRELOAD = 2'b10,
    OP_REMOVE  = 2'b11
  } allocOp_e;

  // strobes from the control FSM to the occupancy datapath
  typedef struct packed {
    logic loadScan;    // start a search: candidate 0, latch exponent
    logic stepScan;    // move to next aligned candidate
    logic markRegion;  // set bits of the current candidate group
    logic freeRegion;  // clear bits of the release group
    logic markOne;     // preload one entry
  } dpCtrl_t;

endpackage

// File: rtl/pow2_region_datapath.sv
module pow2_region_datapath
  import pow2_region_pkg::*;
#(
  parameter int Entries       = 256,
  parameter int CountW        = 16,
  parameter int MaxHandleMask = 5,
  parameter int IndexW        = $clog2(Entries),
  parameter int MaskW         = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [CountW-1:0] reqCount,
  input  logic [IndexW-1:0] reqIndex,
  input  logic [MaskW-1:0]  reqMask,
  input  logic              reqPresent,
  output logic [MaskW-1:0]  allocMask,
  output logic              allocBad,
  output logic              regionFree,
  output logic              scanLast,
  output logic [IndexW-1:0] candIdx,
  output logic [MaskW-1:0]  scanMask,
  output logic              tableEmpty
);

  localparam logic [MaskW-1:0]  MaxMaskC  = MaskW'(MaxHandleMask);
  localparam logic [MaskW-1:0]  IdxWMaskC = MaskW'(IndexW);
  localparam logic [IndexW:0]   EntriesC  = (IndexW+1)'(Entries);

  logic [Entries-1:0] usedMap;
  logic [Entries-1:0] scanOnes;
  logic [Entries-1:0] relOnes;
  logic [IndexW:0]    scanSize;
  logic [IndexW:0]    nextCand;

  // smallest m with 2^m >= c (c of 0 or 1 gives 0)
  function automatic logic [MaskW-1:0] roundMask(input logic [CountW-1:0] c);
    logic [MaskW-1:0] m;
    logic found;
    m = '0;
    found = 1'b0;
    for (int i = 0; i <= CountW; i++) begin
      if (!found && (((CountW+1)'(1) << i) >= {1'b0, c})) begin
        m = MaskW'(i);
        found = 1'b1;
      end
    end
    return m;
  endfunction

  // low 2^m bits set, saturating at the full table
  function automatic logic [Entries-1:0] onesOf(input logic [MaskW-1:0] m);
    if (m >= IdxWMaskC) return '1;
    return ~({Entries{1'b1}} << (32'd1 << m));
  endfunction

  assign allocMask  = roundMask(reqCount);
  assign allocBad   = (reqCount == '0) || (allocMask > MaxMaskC);
  assign scanOnes   = onesOf(scanMask);
  assign relOnes    = onesOf(reqMask);
  assign scanSize   = (IndexW+1)'(1) << scanMask;
  assign nextCand   = {1'b0, candIdx} + scanSize;
  assign scanLast   = (nextCand >= EntriesC);
  assign regionFree = ((usedMap >> candIdx) & scanOnes) == '0;
  assign tableEmpty = (usedMap == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMap  <= '0;
      candIdx  <= '0;
      scanMask <= '0;
    end else begin
      if (ctrl.loadScan) begin
        candIdx  <= '0;
        scanMask <= allocMask;
      end else if (ctrl.stepScan) begin
        candIdx  <= nextCand[IndexW-1:0];
      end
      if (ctrl.markRegion)
        usedMap <= usedMap | (scanOnes << candIdx);
      else if (ctrl.freeRegion)
        usedMap <= usedMap & ~(relOnes << reqIndex);
      else if (ctrl.markOne && reqPresent)
        usedMap[reqIndex] <= 1'b1;
    end
  end

endmodule

// File: rtl/pow2_region_ctrl.sv
module pow2_region_ctrl
  import pow2_region_pkg::*;
#(
  parameter int IndexW     = 8,
  parameter int MaskW      = 5,
  parameter int SubHandleW = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [1:0]            reqOp,
  input  logic [IndexW-1:0]     reqIndex,
  input  logic [MaskW-1:0]      reqMask,
  input  logic [SubHandleW-1:0] reqSubHandle,
  input  logic                  allocBad,
  input  logic                  regionFree,
  input  logic                  scanLast,
  input  logic [IndexW-1:0]     candIdx,
  input  logic [MaskW-1:0]      scanMask,
  input  logic                  tableEmpty,
  output dpCtrl_t               ctrl,
  output logic                  rspValid,
  output logic                  rspOk,
  output logic [IndexW-1:0]     rspIndex,
  output logic [MaskW-1:0]      rspMask,
  output logic                  invValid,
  output logic [IndexW-1:0]     invIndex,
  output logic [MaskW-1:0]      invMask
);

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  state_e            state, stateNext;
  logic              fire, okNext, invNext;
  logic [IndexW-1:0] idxNext;
  logic [MaskW-1:0]  mskNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    fire      = 1'b0;
    okNext    = 1'b0;
    invNext   = 1'b0;
    idxNext   = '0;
    mskNext   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          unique case (allocOp_e'(reqOp))
            OP_ALLOC: begin
              if (allocBad) begin
                fire = 1'b1;
              end else begin
                ctrl.loadScan = 1'b1;
                stateNext     = ST_SCAN;
              end
            end
            OP_RELEASE: begin
              fire   = 1'b1;
              okNext = 1'b1;
              if (reqSubHandle == '0) begin
                ctrl.freeRegion = 1'b1;
                invNext         = 1'b1;
              end
            end
            OP_PRELOAD: begin
              fire         = 1'b1;
              okNext       = 1'b1;
              ctrl.markOne = 1'b1;
            end
            OP_REMOVE: begin
              fire   = 1'b1;
              okNext = tableEmpty;
            end
            default: ;
          endcase
        end
      end
      ST_SCAN: begin
        if (regionFree) begin
          ctrl.markRegion = 1'b1;
          fire            = 1'b1;
          okNext          = 1'b1;
          idxNext         = candIdx;
          mskNext         = scanMask;
          stateNext       = ST_IDLE;
        end else if (scanLast) begin
          fire      = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctrl.stepScan = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspIndex <= '0;
      rspMask  <= '0;
      invValid <= 1'b0;
      invIndex <= '0;
      invMask  <= '0;
    end else begin
      state    <= stateNext;
      rspValid <= fire;
      invValid <= invNext;
      if (fire) begin
        rspOk    <= okNext;
        rspIndex <= idxNext;
        rspMask  <= mskNext;
      end
      if (invNext) begin
        invIndex <= reqIndex;
        invMask  <= reqMask;
      end
    end
  end

endmodule

// File: rtl/pow2_region_alloc.sv
module pow2_region_alloc
  import pow2_region_pkg::*;
#(
  parameter int Entries       = 256,
  parameter int CountW        = 16,
  parameter int MaxHandleMask = 5,
  parameter int SubHandleW    = 4,
  localparam int IndexW       = $clog2(Entries),
  localparam int MaskW        = $clog2(((CountW > IndexW) ? CountW : IndexW) + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [1:0]            reqOp,
  input  logic [CountW-1:0]     reqCount,
  input  logic [IndexW-1:0]     reqIndex,
  input  logic [MaskW-1:0]      reqMask,
  input  logic [SubHandleW-1:0] reqSubHandle,
  input  logic                  reqPresent,
  output logic                  rspValid,
  output logic                  rspOk,
  output logic [IndexW-1:0]     rspIndex,
  output logic [MaskW-1:0]      rspMask,
  output logic                  invValid,
  output logic [IndexW-1:0]     invIndex,
  output logic [MaskW-1:0]      invMask
);

  dpCtrl_t           ctrl;
  logic [MaskW-1:0]  allocMask;
  logic              allocBad;
  logic              regionFree;
  logic              scanLast;
  logic [IndexW-1:0] candIdx;
  logic [MaskW-1:0]  scanMask;
  logic              tableEmpty;

  pow2_region_datapath #(
    .Entries(Entries), .CountW(CountW), .MaxHandleMask(MaxHandleMask),
    .IndexW(IndexW), .MaskW(MaskW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqCount(reqCount), .reqIndex(reqIndex), .reqMask(reqMask),
    .reqPresent(reqPresent),
    .allocMask(allocMask), .allocBad(allocBad), .regionFree(regionFree),
    .scanLast(scanLast), .candIdx(candIdx), .scanMask(scanMask),
    .tableEmpty(tableEmpty)
  );

  pow2_region_ctrl #(
    .IndexW(IndexW), .MaskW(MaskW), .SubHandleW(SubHandleW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqIndex(reqIndex), .reqMask(reqMask), .reqSubHandle(reqSubHandle),
    .allocBad(allocBad), .regionFree(regionFree), .scanLast(scanLast),
    .candIdx(candIdx), .scanMask(scanMask), .tableEmpty(tableEmpty),
    .ctrl(ctrl),
    .rspValid(rspValid), .rspOk(rspOk), .rspIndex(rspIndex), .rspMask(rspMask),
    .invValid(invValid), .invIndex(invIndex), .invMask(invMask)
  );

endmodule

// File: rtl/pow2_region_alloc_checker.sv
module pow2_region_alloc_checker #(
  parameter int Entries       = 256,
  parameter int CountW        = 16,
  parameter int MaxHandleMask = 5,
  parameter int SubHandleW    = 4,
  parameter int IndexW        = 8,
  parameter int MaskW         = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic [1:0]            reqOp,
  input logic [CountW-1:0]     reqCount,
  input logic [IndexW-1:0]     reqIndex,
  input logic [MaskW-1:0]      reqMask,
  input logic [SubHandleW-1:0] reqSubHandle,
  input logic                  rspValid,
  input logic                  rspOk,
  input logic [IndexW-1:0]     rspIndex,
  input logic [MaskW-1:0]      rspMask,
  input logic                  invValid,
  input logic [IndexW-1:0]     invIndex,
  input logic [MaskW-1:0]      invMask
);

  localparam logic [CountW:0]  MaxCountC = (CountW+1)'(1) << MaxHandleMask;
  localparam logic [MaskW-1:0] MaxMaskC  = MaskW'(MaxHandleMask);

  logic takeAlloc, takeRelease, legalCount;
  assign takeAlloc   = reqValid && reqReady && (reqOp == 2'b00);
  assign takeRelease = reqValid && reqReady && (reqOp == 2'b01);
  assign legalCount  = (reqCount != '0) && ({1'b0, reqCount} <= MaxCountC);

  assert_zero_count_fails_R1: assert property (@(posedge clk) disable iff (!rstN)
    (takeAlloc && reqCount == '0) |=> (rspValid && !rspOk));

  assert_oversize_fails_R3: assert property (@(posedge clk) disable iff (!rstN)
    (takeAlloc && ({1'b0, reqCount} > MaxCountC)) |=> (rspValid && !rspOk));

  assert_mask_within_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk) |-> (rspMask <= MaxMaskC));

  assert_base_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk) |-> ((rspIndex & ((IndexW'(1) << rspMask) - IndexW'(1))) == '0));

  assert_release_invalidates_R7: assert property (@(posedge clk) disable iff (!rstN)
    (takeRelease && reqSubHandle == '0) |=>
      (invValid && invIndex == $past(reqIndex) && invMask == $past(reqMask)));

  assert_inv_from_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> $past(takeRelease));

  assert_subhandle_noop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (takeRelease && reqSubHandle != '0) |=> !invValid);

  assert_busy_while_scan_R12: assert property (@(posedge clk) disable iff (!rstN)
    (takeAlloc && legalCount) |=> !reqReady);

endmodule

bind pow2_region_alloc pow2_region_alloc_checker #(
  .Entries(Entries), .CountW(CountW), .MaxHandleMask(MaxHandleMask),
  .SubHandleW(SubHandleW), .IndexW(IndexW), .MaskW(MaskW)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqCount(reqCount), .reqIndex(reqIndex), .reqMask(reqMask),
  .reqSubHandle(reqSubHandle), .rspValid(rspValid), .rspOk(rspOk),
  .rspIndex(rspIndex), .rspMask(rspMask), .invValid(invValid),
  .invIndex(invIndex), .invMask(invMask)
);

// File: tb/pow2_region_alloc_tb_top.sv
module pow2_region_alloc_tb_top;

  localparam int ClkPeriod     = 10;
  localparam int Entries       = 256;
  localparam int CountW        = 16;
  localparam int MaxHandleMask = 5;
  localparam int SubHandleW    = 4;
  localparam int IndexW        = 8;
  localparam int MaskW         = 5;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0;
  logic                  reqReady;
  logic [1:0]            reqOp = '0;
  logic [CountW-1:0]     reqCount = '0;
  logic [IndexW-1:0]     reqIndex = '0;
  logic [MaskW-1:0]      reqMask = '0;
  logic [SubHandleW-1:0] reqSubHandle = '0;
  logic                  reqPresent = 1'b0;
  logic                  rspValid, rspOk, invValid;
  logic [IndexW-1:0]     rspIndex, invIndex;
  logic [MaskW-1:0]      rspMask, invMask;

  pow2_region_alloc #(
    .Entries(Entries), .CountW(CountW), .MaxHandleMask(MaxHandleMask),
    .SubHandleW(SubHandleW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCount(reqCount), .reqIndex(reqIndex), .reqMask(reqMask),
    .reqSubHandle(reqSubHandle), .reqPresent(reqPresent),
    .rspValid(rspValid), .rspOk(rspOk), .rspIndex(rspIndex), .rspMask(rspMask),
    .invValid(invValid), .invIndex(invIndex), .invMask(invMask)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; bit ok; int idx; int msk; string req; } rspExp_t;
  typedef struct { int due; int idx; int msk; string req; } invExp_t;
  rspExp_t rspQ[$];
  invExp_t invQ[$];

  int checks = 0;
  int errors = 0;
  bit model[Entries];

  task automatic check(input bit good, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int maskOf(input int count);
    for (int m = 0; m <= CountW; m++)
      if ((1 << m) >= count) return m;
    return CountW + 1;
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    rspExp_t r;
    invExp_t v;
    if (rstN) begin
      if (rspValid) begin
        if (rspQ.size() == 0) check(1'b0, "R4", "unexpected response", 1, 0);
        else begin
          r = rspQ.pop_front();
          check(cyc == r.due, r.req, "response cycle", cyc, r.due);
          check(rspOk == r.ok, r.req, "rspOk", int'(rspOk), int'(r.ok));
          check(int'(rspIndex) == r.idx, r.req, "rspIndex", int'(rspIndex), r.idx);
          check(int'(rspMask) == r.msk, r.req, "rspMask", int'(rspMask), r.msk);
        end
      end else if (rspQ.size() != 0 && rspQ[0].due < cyc) begin
        r = rspQ.pop_front();
        check(1'b0, r.req, "missing response at cycle", cyc, r.due);
      end
      if (invValid) begin
        if (invQ.size() == 0) check(1'b0, "R8", "unexpected invalidate", 1, 0);
        else begin
          v = invQ.pop_front();
          check(cyc == v.due, v.req, "invalidate cycle", cyc, v.due);
          check(int'(invIndex) == v.idx, v.req, "invIndex", int'(invIndex), v.idx);
          check(int'(invMask) == v.msk, v.req, "invMask", int'(invMask), v.msk);
        end
      end else if (invQ.size() != 0 && invQ[0].due < cyc) begin
        v = invQ.pop_front();
        check(1'b0, v.req, "missing invalidate at cycle", cyc, v.due);
      end
    end
  end

  // driver: issues one request, predicts its results from the reference map
  task automatic send(input int op, input int count, input int idx, input int msk,
                      input int sub, input bit present, input string req);
    int p;
    int m;
    int size;
    int j;
    int found;
    bit scanning;
    bit empty;
    reqValid     = 1'b1;
    reqOp        = 2'(op);
    reqCount     = CountW'(count);
    reqIndex     = IndexW'(idx);
    reqMask      = MaskW'(msk);
    reqSubHandle = SubHandleW'(sub);
    reqPresent   = present;
    while (!reqReady) @(negedge clk);
    p = cyc;
    scanning = 1'b0;
    case (op)
      0: begin
        m = maskOf(count);
        if (count == 0 || m > MaxHandleMask) begin
          rspQ.push_back('{p + 1, 1'b0, 0, 0, req});
        end else begin
          scanning = 1'b1;
          size = 1 << m;
          found = -1;
          j = 0;
          for (int b = 0; b < Entries; b += size) begin
            bit free = 1'b1;
            for (int k = 0; k < size; k++) if (model[b + k]) free = 1'b0;
            if (free) begin found = b; break; end
            j++;
          end
          if (found >= 0) begin
            for (int k = 0; k < size; k++) model[found + k] = 1'b1;
            rspQ.push_back('{p + 2 + j, 1'b1, found, m, req});
          end else begin
            rspQ.push_back('{p + 1 + Entries / size, 1'b0, 0, 0, req});
          end
        end
      end
      1: begin
        rspQ.push_back('{p + 1, 1'b1, 0, 0, req});
        if (sub == 0) begin
          for (int k = 0; k < (1 << msk); k++)
            if (idx + k < Entries) model[idx + k] = 1'b0;
          invQ.push_back('{p + 1, idx, msk, req});
        end
      end
      2: begin
        if (present) model[idx] = 1'b1;
        rspQ.push_back('{p + 1, 1'b1, 0, 0, req});
      end
      default: begin
        empty = 1'b1;
        for (int k = 0; k < Entries; k++) if (model[k]) empty = 1'b0;
        rspQ.push_back('{p + 1, empty, 0, 0, req});
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (scanning) check(!reqReady, "R12", "reqReady during search", int'(reqReady), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish, cycle", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < Entries; k++) model[k] = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(reqReady == 1'b1, "R11", "reqReady in reset", int'(reqReady), 1);
    check(rspValid == 1'b0, "R11", "rspValid in reset", int'(rspValid), 0);
    check(invValid == 1'b0, "R11", "invValid in reset", int'(invValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    send(3, 0, 0, 0, 0, 0, "R11 R10 empty after reset");
    send(0, 0, 0, 0, 0, 0, "R1 zero count");
    send(0, 33, 0, 0, 0, 0, "R3 oversize count");
    send(0, 32, 0, 0, 0, 0, "R2 R4 count 32");
    send(0, 1, 0, 0, 0, 0, "R2 R4 count 1");
    send(0, 3, 0, 0, 0, 0, "R2 R5 count 3");
    send(0, 5, 0, 0, 0, 0, "R2 R5 count 5");
    send(3, 0, 0, 0, 0, 0, "R10 busy");
    send(1, 0, 32, 0, 3, 0, "R8 subhandle release");
    send(0, 1, 0, 0, 0, 0, "R8 entry still held");
    send(1, 0, 0, 5, 0, 0, "R7 release group");
    send(0, 2, 0, 0, 0, 0, "R7 R4 reuse freed");
    send(2, 0, 100, 0, 0, 1, "R9 preload present");
    send(2, 0, 200, 0, 0, 0, "R9 preload absent");
    for (int n = 0; n < 6; n++) send(0, 32, 0, 0, 0, 0, "R9 R6 fill by 32");
    send(0, 1, 0, 0, 0, 0, "R6 map unchanged after fail");
    send(1, 0, 0, 8, 0, 0, "R7 release whole table");
    send(3, 0, 0, 0, 0, 0, "R10 granted when empty");
    for (int w = 0; w < 400 && (rspQ.size() != 0 || invQ.size() != 0); w++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    check(rspQ.size() == 0, "R4", "responses left over", rspQ.size(), 0);
    check(invQ.size() == 0, "R7", "invalidates left over", invQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule